// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management-bus master for Ethernet PHYs. A host writes one 32-bit command word into a single register. The word is packed with start bits, an opcode, the PHY address, the register address, a turnaround code and 16 data bits. The engine sends a 32-bit all-ones preamble and then shifts the word out serially on the management data line. It generates the management clock from the system clock while it does this. On a read it releases the data line during the turnaround and data bits. The 16 bits it samples from the PHY replace the low half of the command register, and the host reads them back from that register.

The host polls the `idle` flag to learn when a frame has finished. A 2-bit ratio input picks the management clock: the system clock divided by 8, 16, 32 or 64. Pick the ratio from the system clock frequency so the management clock stays in range. Use /8 up to 20 MHz, /16 up to 40 MHz, /32 up to 80 MHz and /64 above that. A port-enable input must be high for a frame to start. The command write is a plain register strobe with no back-pressure. A write that arrives while the engine is busy is dropped. The host must wait until `idle` reads 1 before writing the next command.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0.
- R2: A `cmd_wr` pulse while `port_en` is 1 and `idle` is 1 latches `cmd_wdata` and drops `idle` at the next clock edge. `idle` then stays 0 for exactly 64 x ratio system clock cycles. The ratio is 8, 16, 32 or 64 for `div_sel` = 0, 1, 2 or 3, taken at the moment the command is accepted.
- R3: During a frame `mdc` is a square wave with a period of ratio system clocks. It is high for half of each period and gives exactly 64 rising edges per frame. `mdc` is 0 whenever `idle` is 1.
- R4: At the rising edges of `mdc`, the line shows 32 preamble bits of 1 and then command bits 31 down to 0. The command fields are: [31:30] start (01), [29:28] opcode (10 = read, 01 = write), [27:23] PHY address, [22:18] register address, [17:16] turnaround (10), [15:0] data.
- R5: `mdio_o` and `mdio_oe` change only on the system clock edge where `mdc` falls. They hold steady while `mdc` is high.
- R6: For a read (opcode 10), `mdio_oe` is 0 for the last 18 bit times (turnaround and data). For a write, `mdio_oe` is 1 for all 64 bit times. `mdio_oe` is 0 while idle.
- R7: After a read, `cmd_rdata[15:0]` holds the 16 bits sampled on `mdio_i` at the last 16 rising `mdc` edges, first sample in bit 15. `cmd_rdata[31:16]` is unchanged.
- R8: A `cmd_wr` while `idle` is 0 is ignored. The frame in progress is not restarted or lengthened, and the command register is not overwritten.
- R9: A `cmd_wr` while `port_en` is 0 is ignored. No frame starts, `mdc` stays 0 and `cmd_rdata` is unchanged.
- R10: After a write frame, `cmd_rdata` still equals the word that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC ratio select: 0=/8, 1=/16, 2=/32, 3=/64 |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register contents, read data in [15:0] |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach is a command write that lands in the middle of a frame in progress. The engine must neither restart the frame nor overwrite the register with the new word. The bench gets there by pulsing `cmd_wr` with the inverted word 100 cycles into a read frame. It then confirms two things: the idle-low interval is still exactly 64 x ratio, and the read-back word matches the first command with the PHY reply in the low half. A bench model of the PHY drives the reply bits after each falling `mdc` edge. The same model records the line at each rising edge. This makes the turnaround release and the data-capture timing visible at the ports for every ratio.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int OP_HI    = 29;
  localparam int OP_LO    = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int TA_BITS  = 2;

  typedef enum logic [1:0] {
    RATIO_8  = 2'd0,
    RATIO_16 = 2'd1,
    RATIO_32 = 2'd2,
    RATIO_64 = 2'd3
  } mdc_ratio_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_BASE = 4,
  parameter int CNT_W     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] ratio,
  output logic       mdc,
  output logic       rise_stb,
  output logic       fall_stb
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_lim;
  logic             mdc_q;
  logic             wrap;

  assign half_lim = CNT_W'((HALF_BASE << ratio) - 1);
  assign wrap     = run && (cnt_q == half_lim);
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_eng_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] cap_data
);
  localparam int FRAME_BITS  = PRE_BITS + CMD_W;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int SEL_W       = $clog2(CMD_W);
  localparam int LAST_IDX    = FRAME_BITS - 1;
  localparam int DATA_IDX    = FRAME_BITS - DATA_W;
  localparam int RELEASE_IDX = DATA_IDX - TA_BITS;

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CMD_W-1:0]  word_q;
  logic              rd_q;
  logic [DATA_W-1:0] cap_q;
  logic              at_last;
  logic              in_pre;
  logic [SEL_W-1:0]  sel;
  logic              bit_val;
  logic              released;

  assign at_last  = (idx_q == IDX_W'(LAST_IDX));
  assign in_pre   = (idx_q < IDX_W'(PRE_BITS));
  assign sel      = SEL_W'(IDX_W'(LAST_IDX) - idx_q);
  assign bit_val  = in_pre ? 1'b1 : word_q[sel];
  assign released = rd_q && (idx_q >= IDX_W'(RELEASE_IDX));

  assign busy     = busy_q;
  assign done     = busy_q && fall_stb && at_last;
  assign mdio_oe  = busy_q && !released;
  assign mdio_o   = mdio_oe ? bit_val : 1'b0;
  assign cap_data = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        word_q <= cmd;
        rd_q   <= (cmd[OP_HI:OP_LO] == OP_READ);
        cap_q  <= '0;
      end
    end else begin
      if (rise_stb && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (at_last) busy_q <= 1'b0;
        else         idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int PRE_BITS  = 32,
  parameter int HALF_BASE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic [1:0]  div_sel,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CNT_W = $clog2(HALF_BASE << 3) + 1;

  logic [CMD_W-1:0]  cmd_q;
  logic [1:0]        ratio_q;
  logic              accept;
  logic              busy;
  logic              done;
  logic              rise_stb;
  logic              fall_stb;
  logic [DATA_W-1:0] cap_data;

  assign accept    = cmd_wr && port_en && !busy;
  assign idle      = !busy;
  assign cmd_rdata = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ratio_q <= RATIO_8;
    end else if (accept) begin
      cmd_q   <= cmd_wdata;
      ratio_q <= div_sel;
    end else if (done && (cmd_q[OP_HI:OP_LO] == OP_READ)) begin
      cmd_q[DATA_W-1:0] <= cap_data;
    end
  end

  mdio_clkgen #(.HALF_BASE(HALF_BASE), .CNT_W(CNT_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .ratio    (ratio_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .cmd      (cmd_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .cap_data (cap_data)
  );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        port_en,
  input logic [1:0]  div_sel,
  input logic        cmd_wr,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        mdio_i
);
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(cmd_wr && port_en));

  assert_mdc_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdc);

  assert_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdio_oe);

  assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd_wr) |=> (cmd_rdata[31:16] == $past(cmd_rdata[31:16])));

  assert_disabled_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_wr && !port_en) |=> idle);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (.*);

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
module sim_mdio_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        idle, mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0;
  int fails = 0;

  // PHY model state
  int          nf = 0;
  int          nr = 0;
  logic [15:0] reply = '0;
  logic [63:0] obs_o = '0;
  logic [63:0] obs_oe = '0;

  always #4 clk = ~clk;

  mdio_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (nf >= 48 && nf <= 63) ? reply[63 - nf] : 1'b1;

  always @(negedge mdc) nf = nf + 1;
  always @(posedge mdc) begin
    if (nr < 64) begin
      obs_o[63 - nr]  = mdio_o;
      obs_oe[63 - nr] = mdio_oe;
    end
    nr = nr + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_xfer(input logic [1:0] r, input logic [31:0] w,
                         input logic [15:0] rep, input bit poke);
    int n;
    int lowcnt;
    int hicnt;
    bit rd;
    logic [63:0] exp_o;
    logic [63:0] exp_oe;
    n  = 8 << r;
    rd = (w[29:28] == 2'b10);
    @(negedge clk);
    div_sel = r; reply = rep; nf = 0; nr = 0;
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    lowcnt = 0; hicnt = 0;
    while (!idle && lowcnt < 10000) begin
      cmd_wr = (poke && lowcnt == 100);
      cmd_wdata = ~w;
      if (mdc) hicnt++;
      lowcnt++;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    chk("R2 busy length", 64'(lowcnt), 64'(64 * n));
    chk("R3 mdc high cycles", 64'(hicnt), 64'(32 * n));
    chk("R3 mdc rising edges", 64'(nr), 64'd64);
    exp_o  = {32'hFFFF_FFFF, w};
    exp_oe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : {64{1'b1}};
    chk("R6 output enable pattern", obs_oe, exp_oe);
    chk("R4 frame bits", obs_o & exp_oe, exp_o & exp_oe);
    if (rd) chk(poke ? "R8 read-back after busy write" : "R7 read-back",
                64'(cmd_rdata), 64'({w[31:16], rep}));
    else    chk("R10 write keeps word", 64'(cmd_rdata), 64'(w));
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [31:0] held;
    int          mdc_seen;
    repeat (3) @(negedge clk);
    chk("R1 idle", 64'(idle), 64'd1);
    chk("R1 mdc", 64'(mdc), 64'd0);
    chk("R1 oe", 64'(mdio_oe), 64'd0);
    chk("R1 cmd_rdata", 64'(cmd_rdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    port_en = 1'b1;

    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) begin
        w = {2'b01, 2'b01, 5'(k * 11 + r), 5'(31 - k * 7), 2'b10, 16'(16'hA5C3 ^ (k * 16'h1111) ^ r)};
        do_xfer(2'(r), w, 16'h0, 1'b0);
        w = {2'b01, 2'b10, 5'(k * 5 + 3), 5'(r * 8 + k), 2'b10, 16'h0000};
        do_xfer(2'(r), w, 16'(16'h8001 ^ (r * 16'h0F0F) ^ (k * 16'h3C3C)), 1'b0);
      end
    end

    // busy write is ignored
    do_xfer(2'd1, {2'b01, 2'b10, 5'd9, 5'd2, 2'b10, 16'h0}, 16'hBEEF, 1'b1);

    // disabled port ignores write
    held = cmd_rdata;
    port_en = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = 32'h5555_1234;
    @(negedge clk);
    cmd_wr = 1'b0;
    mdc_seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (!idle || mdc) mdc_seen++;
      @(negedge clk);
    end
    chk("R9 no frame when disabled", 64'(mdc_seen), 64'd0);
    chk("R9 register unchanged", 64'(cmd_rdata), 64'(held));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule